// File: doc/BRIEF.md
# I2C Bus Transaction Monitor

This block listens to the two wires of an I2C bus and never drives them. It samples both lines with a fast system clock and passes each through a synchronizer. From the synchronized lines it recognizes START, repeated START and STOP conditions. It assembles bytes from the bits taken on SCL rising edges. Each finished byte, and each bus condition, becomes one event record on a single-cycle output strobe.

The first byte after any START is taken as the address byte. Its low bit sets the transfer direction, and every data byte that follows carries the read or write tag of the most recent address. The event output is a plain strobe with no ready input. A passive observer cannot hold the bus, so the block offers no back-pressure: the consumer must accept a record in every cycle where the strobe is high.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After a synchronous reset the outputs are low and zero (evt_valid 0, evt_code 0, evt_byte 0, evt_nack 0). Line levels that were already present when reset ended produce no event.
- R2: While the block is waiting for a transfer, an SDA fall while SCL is high produces a START event with evt_code 0, evt_byte 0 and evt_nack 0.
- R3: Bits are taken only on SCL rising edges. A byte is 8 bits sent MSB first, followed by a ninth bit that sets evt_nack (high means NACK). The first byte after a START is reported with evt_byte holding its upper 7 bits, zero-extended. Its low bit selects evt_code 2 (write, bit 0) or 3 (read, bit 1).
- R4: Any number of data bytes may follow an address. Each is reported with all 8 bits in evt_byte and the ninth bit in evt_nack. Its evt_code is 4 if the latest address was a write and 5 if it was a read.
- R5: While data bytes are expected, an SDA rise while SCL is high produces a STOP event (evt_code 6, evt_byte 0, evt_nack 0) and returns the block to waiting. While waiting, every line activity other than a START produces no event.
- R6: While the address byte is being collected, SDA changes while SCL is high are not treated as START or STOP. Only SCL rising edges count.
- R7: A START that follows an earlier START with no STOP in between is reported with evt_code 1. After a STOP, the next START is reported with evt_code 0 again.
- R8: While data bytes are expected, a sample that holds both an SCL rising edge and an SDA fall is taken as a data bit, not as a repeated START.
- R9: evt_valid is high for exactly one cycle per event, and evt_code never exceeds 6.
- R10: A reset in the middle of a transfer clears the byte collection, the state and the repeated-START tracking, so the next START is reported with evt_code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Observed serial clock line level |
| sda_in | input | 1 | Observed serial data line level |
| evt_valid | output | 1 | One-cycle strobe marking a new event record |
| evt_code | output | 3 | Event kind: 0 START, 1 repeated START, 2 address write, 3 address read, 4 data write, 5 data read, 6 STOP |
| evt_byte | output | BYTE_W | Address (zero-extended) or data byte; zero for bus conditions |
| evt_nack | output | 1 | Ninth bit of the byte; zero for bus conditions |

## Verification
A corrupted bit counter or shift register shows up at the ports on the next byte event. That event carries a shifted or misaligned value, or it comes one bit early or late, which then changes how every later event in the transfer is tagged. A wrong state or a stale repeated-START flag becomes visible at the next bus condition. A START then gets the wrong code, a STOP goes missing, or a START or STOP appears inside an address byte. The bound checker follows the event stream through the port values alone. It flags a data event with no address before it, a second address without a START, a direction tag that disagrees with the latest address, and a START code that does not match the open or closed transfer.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

  localparam int EVT_CODE_W = 3;

  typedef enum logic [EVT_CODE_W-1:0] {
    EV_START    = 3'd0,
    EV_RSTART   = 3'd1,
    EV_ADDR_WR  = 3'd2,
    EV_ADDR_RD  = 3'd3,
    EV_DATA_WR  = 3'd4,
    EV_DATA_RD  = 3'd5,
    EV_STOP     = 3'd6
  } evt_code_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } mon_state_e;

  typedef struct packed {
    logic scl_rise;
    logic start_seen;
    logic stop_seen;
    logic sda_now;
  } line_evt_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= din;
    for (int i = 1; i < STAGES; i++) begin
      stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
  import i2cmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      scl_s,
  input  logic      sda_s,
  output line_evt_t ev
);

  logic primed_q;
  logic scl_q;
  logic sda_q;

  // Previous-level registers follow the synchronized lines every cycle.
  // The primed flag blocks edge reporting in the first cycle after reset.
  always_ff @(posedge clk) begin
    scl_q <= scl_s;
    sda_q <= sda_s;
    if (rst) primed_q <= 1'b0;
    else     primed_q <= 1'b1;
  end

  always_comb begin
    ev.sda_now    = sda_s;
    ev.scl_rise   = primed_q & ~scl_q & scl_s;
    ev.start_seen = primed_q & sda_q & ~sda_s & scl_s;
    ev.stop_seen  = primed_q & ~sda_q & sda_s & scl_s;
  end

endmodule

// File: rtl/i2cmon_fsm.sv
module i2cmon_fsm
  import i2cmon_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  line_evt_t             ev,
  output logic                  evt_valid,
  output logic [EVT_CODE_W-1:0] evt_code,
  output logic [BYTE_W-1:0]     evt_byte,
  output logic                  evt_nack
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(BYTE_W);

  mon_state_e          st_q, st_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [BYTE_W-1:0]   sh_q, sh_n;
  logic                rep_q, rep_n;
  logic                rd_q, rd_n;
  logic                v_q, v_n;
  evt_code_e           code_q, code_n;
  logic [BYTE_W-1:0]   byte_q, byte_n;
  logic                nack_q, nack_n;
  logic                frame_end;

  // The bit now arriving is the acknowledge bit when all payload bits are in.
  assign frame_end = (cnt_q == CNT_FRAME);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    rep_n  = rep_q;
    rd_n   = rd_q;
    v_n    = 1'b0;
    code_n = code_q;
    byte_n = byte_q;
    nack_n = nack_q;
    unique case (st_q)
      ST_HUNT: begin
        if (ev.start_seen) begin
          v_n    = 1'b1;
          code_n = rep_q ? EV_RSTART : EV_START;
          byte_n = '0;
          nack_n = 1'b0;
          st_n   = ST_ADDR;
          cnt_n  = '0;
          sh_n   = '0;
          rep_n  = 1'b1;
        end
      end
      ST_ADDR: begin
        if (ev.scl_rise) begin
          if (frame_end) begin
            v_n    = 1'b1;
            code_n = sh_q[0] ? EV_ADDR_RD : EV_ADDR_WR;
            byte_n = {1'b0, sh_q[BYTE_W-1:1]};
            nack_n = ev.sda_now;
            rd_n   = sh_q[0];
            st_n   = ST_DATA;
            cnt_n  = '0;
          end else begin
            sh_n  = {sh_q[BYTE_W-2:0], ev.sda_now};
            cnt_n = cnt_q + CNT_ONE;
          end
        end
      end
      ST_DATA: begin
        if (ev.scl_rise) begin
          if (frame_end) begin
            v_n    = 1'b1;
            code_n = rd_q ? EV_DATA_RD : EV_DATA_WR;
            byte_n = sh_q;
            nack_n = ev.sda_now;
            cnt_n  = '0;
          end else begin
            sh_n  = {sh_q[BYTE_W-2:0], ev.sda_now};
            cnt_n = cnt_q + CNT_ONE;
          end
        end else if (ev.start_seen) begin
          v_n    = 1'b1;
          code_n = rep_q ? EV_RSTART : EV_START;
          byte_n = '0;
          nack_n = 1'b0;
          st_n   = ST_ADDR;
          cnt_n  = '0;
          sh_n   = '0;
          rep_n  = 1'b1;
        end else if (ev.stop_seen) begin
          v_n    = 1'b1;
          code_n = EV_STOP;
          byte_n = '0;
          nack_n = 1'b0;
          st_n   = ST_HUNT;
          cnt_n  = '0;
          rep_n  = 1'b0;
        end
      end
      default: begin
        st_n = ST_HUNT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HUNT;
      cnt_q  <= '0;
      sh_q   <= '0;
      rep_q  <= 1'b0;
      rd_q   <= 1'b0;
      v_q    <= 1'b0;
      code_q <= EV_START;
      byte_q <= '0;
      nack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      rep_q  <= rep_n;
      rd_q   <= rd_n;
      v_q    <= v_n;
      code_q <= code_n;
      byte_q <= byte_n;
      nack_q <= nack_n;
    end
  end

  assign evt_valid = v_q;
  assign evt_code  = code_q;
  assign evt_byte  = byte_q;
  assign evt_nack  = nack_q;

endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2cmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              evt_valid,
  output logic [2:0]        evt_code,
  output logic [BYTE_W-1:0] evt_byte,
  output logic              evt_nack
);

  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  line_evt_t        line_ev;

  i2cmon_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINES)
  ) sync_i (
    .clk  (clk),
    .din  ({scl_in, sda_in}),
    .dout (lines_s)
  );

  i2cmon_cond_detect cond_i (
    .clk   (clk),
    .rst   (rst),
    .scl_s (lines_s[1]),
    .sda_s (lines_s[0]),
    .ev    (line_ev)
  );

  i2cmon_fsm #(
    .BYTE_W (BYTE_W)
  ) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .ev        (line_ev),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_byte  (evt_byte),
    .evt_nack  (evt_nack)
  );

endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic [2:0]        evt_code,
  input logic [BYTE_W-1:0] evt_byte,
  input logic              evt_nack
);

  // Transfer tracking rebuilt from the event stream only.
  logic open_q;
  logic addr_seen_q;
  logic last_rd_q;
  logic is_marker;
  logic is_addr;
  logic is_data;

  assign is_marker = evt_valid && (evt_code == 3'd0 || evt_code == 3'd1 || evt_code == 3'd6);
  assign is_addr   = evt_valid && (evt_code == 3'd2 || evt_code == 3'd3);
  assign is_data   = evt_valid && (evt_code == 3'd4 || evt_code == 3'd5);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      addr_seen_q <= 1'b0;
      last_rd_q   <= 1'b0;
    end else if (evt_valid) begin
      if (evt_code == 3'd0 || evt_code == 3'd1) begin
        open_q      <= 1'b1;
        addr_seen_q <= 1'b0;
      end else if (evt_code == 3'd6) begin
        open_q      <= 1'b0;
        addr_seen_q <= 1'b0;
      end else if (is_addr) begin
        addr_seen_q <= 1'b1;
        last_rd_q   <= evt_code[0];
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !evt_valid); // R1
  AST_MARKER_EMPTY: assert property (@(posedge clk) disable iff (rst) is_marker |-> (evt_byte == '0 && !evt_nack)); // R2
  AST_ADDR_ZEXT: assert property (@(posedge clk) disable iff (rst) is_addr |-> !evt_byte[BYTE_W-1]); // R3
  AST_DATA_DIR: assert property (@(posedge clk) disable iff (rst) is_data |-> (addr_seen_q && evt_code[0] == last_rd_q)); // R4
  AST_STOP_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst) (evt_valid && evt_code == 3'd6) |-> addr_seen_q); // R5
  AST_ADDR_ONCE: assert property (@(posedge clk) disable iff (rst) is_addr |-> (open_q && !addr_seen_q)); // R6
  AST_PLAIN_START: assert property (@(posedge clk) disable iff (rst) (evt_valid && evt_code == 3'd0) |-> !open_q); // R7
  AST_REP_START: assert property (@(posedge clk) disable iff (rst) (evt_valid && evt_code == 3'd1) |-> open_q); // R7
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst) evt_valid |-> (evt_code <= 3'd6)); // R9

endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk #(
  .BYTE_W (BYTE_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .evt_valid (evt_valid),
  .evt_code  (evt_code),
  .evt_byte  (evt_byte),
  .evt_nack  (evt_nack)
);

// File: tb/i2c_bus_monitor_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_monitor_tb_top;

  localparam int HP    = 3;
  localparam int MAXEV = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       evt_valid;
  logic [2:0] evt_code;
  logic [7:0] evt_byte;
  logic       evt_nack;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  logic [2:0] exp_code [MAXEV];
  logic [7:0] exp_byte [MAXEV];
  logic       exp_nack [MAXEV];
  logic [2:0] act_code [MAXEV];
  logic [7:0] act_byte [MAXEV];
  logic       act_nack [MAXEV];
  int exp_n = 0;
  int act_n = 0;

  always #4 clk = ~clk;

  i2c_bus_monitor #(.SYNC_STAGES(2), .BYTE_W(8)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl),
    .sda_in    (sda),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_byte  (evt_byte),
    .evt_nack  (evt_nack)
  );

  // Each high cycle of the strobe is one record (a stretched pulse shows as extra records: R9).
  always @(negedge clk) begin
    if (!rst && evt_valid) begin
      if (act_n < MAXEV) begin
        act_code[act_n] = evt_code;
        act_byte[act_n] = evt_byte;
        act_nack[act_n] = evt_nack;
      end
      act_n = act_n + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_evt(input logic [2:0] c, input logic [7:0] b, input logic n);
    exp_code[exp_n] = c;
    exp_byte[exp_n] = b;
    exp_nack[exp_n] = n;
    exp_n++;
  endtask

  task automatic compare(input string req);
    tick(12);
    check(act_n == exp_n, req, "event count (R9)", act_n, exp_n);
    for (int i = 0; i < act_n && i < exp_n; i++) begin
      check(act_code[i] == exp_code[i], req, "evt_code", int'(act_code[i]), int'(exp_code[i]));
      check(act_byte[i] == exp_byte[i], req, "evt_byte", int'(act_byte[i]), int'(exp_byte[i]));
      check(act_nack[i] == exp_nack[i], req, "evt_nack", int'(act_nack[i]), int'(exp_nack[i]));
    end
    act_n = 0;
    exp_n = 0;
  endtask

  task automatic bus_start();
    sda = 1'b0; tick(HP);
    scl = 1'b0; tick(HP);
  endtask

  task automatic bus_bit(input logic b);
    sda = b;    tick(HP);
    scl = 1'b1; tick(2*HP);
    scl = 1'b0; tick(HP);
  endtask

  task automatic bus_byte(input logic [7:0] b, input logic n);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(n);
  endtask

  task automatic bus_stop();
    sda = 1'b0; tick(HP);
    scl = 1'b1; tick(HP);
    sda = 1'b1; tick(HP);
  endtask

  task automatic bus_rstart();
    sda = 1'b1; tick(HP);
    scl = 1'b1; tick(HP);
    sda = 1'b0; tick(HP);
    scl = 1'b0; tick(HP);
  endtask

  initial begin
    // R1: reset state, and SDA already low with SCL high gives no START.
    scl = 1'b1; sda = 1'b0; rst = 1'b1;
    tick(6);
    check(evt_valid == 1'b0, "R1", "evt_valid in reset", int'(evt_valid), 0);
    check(evt_code == 3'd0,  "R1", "evt_code in reset", int'(evt_code), 0);
    check(evt_byte == 8'd0,  "R1", "evt_byte in reset", int'(evt_byte), 0);
    check(evt_nack == 1'b0,  "R1", "evt_nack in reset", int'(evt_nack), 0);
    rst = 1'b0;
    tick(10);
    compare("R1");

    // R5: while waiting, a STOP-like edge and SCL toggling are ignored.
    sda = 1'b1; tick(HP);
    for (int k = 0; k < 6; k++) begin
      scl = 1'b0; tick(HP);
      sda = k[0]; tick(HP);
      scl = 1'b1; tick(HP);
    end
    sda = 1'b1; tick(HP);
    compare("R5 idle");

    // R2 R3 R4 R5: write transfer with two data bytes.
    bus_start();                expect_evt(3'd0, 8'h00, 1'b0);
    bus_byte({7'h50, 1'b0}, 0); expect_evt(3'd2, 8'h50, 1'b0);
    bus_byte(8'hA5, 1'b0);      expect_evt(3'd4, 8'hA5, 1'b0);
    bus_byte(8'h3C, 1'b1);      expect_evt(3'd4, 8'h3C, 1'b1);
    bus_stop();                 expect_evt(3'd6, 8'h00, 1'b0);
    compare("R2 R3 R4 R5");

    // R7: repeated START, then STOP clears the tracking.
    bus_start();                expect_evt(3'd0, 8'h00, 1'b0);
    bus_byte({7'h21, 1'b0}, 0); expect_evt(3'd2, 8'h21, 1'b0);
    bus_byte(8'h07, 1'b0);      expect_evt(3'd4, 8'h07, 1'b0);
    bus_rstart();               expect_evt(3'd1, 8'h00, 1'b0);
    bus_byte({7'h21, 1'b1}, 0); expect_evt(3'd3, 8'h21, 1'b0);
    bus_byte(8'hE8, 1'b1);      expect_evt(3'd5, 8'hE8, 1'b1);
    bus_stop();                 expect_evt(3'd6, 8'h00, 1'b0);
    bus_start();                expect_evt(3'd0, 8'h00, 1'b0);
    bus_byte({7'h33, 1'b0}, 1); expect_evt(3'd2, 8'h33, 1'b1);
    bus_stop();                 expect_evt(3'd6, 8'h00, 1'b0);
    compare("R7");

    // R6: STOP and START shapes inside the address byte are ignored.
    bus_start();                expect_evt(3'd0, 8'h00, 1'b0);
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    sda = 1'b0; tick(HP);
    scl = 1'b1; tick(HP);
    sda = 1'b1; tick(HP);
    sda = 1'b0; tick(HP);
    scl = 1'b0; tick(HP);
    bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
    bus_bit(1'b0);              expect_evt(3'd3, 8'h56, 1'b0);
    bus_stop();                 expect_evt(3'd6, 8'h00, 1'b0);
    compare("R6");

    // R8: SCL rise and SDA fall in the same sample are a data bit.
    bus_start();                expect_evt(3'd0, 8'h00, 1'b0);
    bus_byte({7'h12, 1'b0}, 0); expect_evt(3'd2, 8'h12, 1'b0);
    sda = 1'b1; tick(HP);
    scl = 1'b1; sda = 1'b0; tick(2*HP);
    scl = 1'b0; tick(HP);
    for (int i = 6; i >= 0; i--) bus_bit(logic'((8'h35 >> i) & 8'h01));
    bus_bit(1'b1);              expect_evt(3'd4, 8'h35, 1'b1);
    bus_stop();                 expect_evt(3'd6, 8'h00, 1'b0);
    compare("R8");

    // R10: reset inside a transfer, next START is plain.
    bus_start();                expect_evt(3'd0, 8'h00, 1'b0);
    bus_bit(1'b1); bus_bit(1'b1);
    compare("R10 pre");
    rst = 1'b1; tick(4);
    rst = 1'b0; tick(2);
    sda = 1'b1; tick(HP);
    scl = 1'b1; tick(4);
    bus_start();                expect_evt(3'd0, 8'h00, 1'b0);
    bus_byte(8'hFF, 1'b0);      expect_evt(3'd3, 8'h7F, 1'b0);
    bus_stop();                 expect_evt(3'd6, 8'h00, 1'b0);
    compare("R10");

    // R3 R4 sweep: every address in both directions, computed data bytes.
    for (int a = 0; a < 128; a++) begin
      for (int d = 0; d < 2; d++) begin
        logic [7:0] b1;
        logic       na;
        b1 = 8'((a * 37 + d * 101) & 255);
        na = (a % 5 == 0);
        bus_start();                        expect_evt(3'd0, 8'h00, 1'b0);
        bus_byte({7'(a), 1'(d)}, na);       expect_evt(d ? 3'd3 : 3'd2, 8'(a), na);
        bus_byte(b1, 1'(a & 1));            expect_evt(d ? 3'd5 : 3'd4, b1, 1'(a & 1));
        bus_byte(~b1, 1'(d));               expect_evt(d ? 3'd5 : 3'd4, ~b1, 1'(d));
        bus_stop();                         expect_evt(3'd6, 8'h00, 1'b0);
        compare("R3 R4 sweep");
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule